// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave Controller

This block is the device-side logic of a serially accessed byte-wide static memory with a 17-bit address space. A host frames each access with an active-low select and a serial clock. Commands, addresses and write data arrive on one, two or four data lines, and read data leaves on the same lines. The engine decodes the opcode, gathers a three-byte address and then moves data to or from an internal synchronous array. After each byte the address either holds (single-byte access), wraps inside a 32-byte page, or runs through the whole address space.

The serial clock is not used as a clock. It is oversampled by the system clock `clk`, and its rising and falling transitions become one-cycle strobes. Inputs are sampled on rising transitions. Outputs change only on falling transitions. The serial pins are assumed to be already synchronous to `clk`. The backing array model holds 2^ARRAY_AW bytes, and upper address bits alias onto it. The address counter itself is always the full 17 bits wide, and ARRAY_AW=17 gives the full-size array.

Top module: `sramx_serial_slave`

## Requirements
- R1: After reset, or while `cs_n` is high, every `sio_oe` bit is 0. After reset the block is in single-line mode with transfer mode "single byte", so a mode-register read returns 0x00.
- R2: In single-line mode, opcode, address and data are sampled MSB first from `sio_in[0]` on serial-clock rising edges. Read data is driven MSB first on `sio_out[1]` with no dummy cycles. `sio_out` changes only in the `clk` cycle that detects a serial-clock falling edge.
- R3: The opcodes are 0x02 write, 0x03 read, 0x01 mode-register write, 0x05 mode-register read, 0x3B two-line mode, 0x38 four-line mode and 0xFF single-line mode. Any other opcode is ignored: the memory is unchanged and no output is enabled.
- R4: The address is three bytes, MSB first. Only its low 17 bits are used.
- R5: In single-byte transfer mode (mode bits 00 or 11), a write stores one byte and ignores further bytes. A read delivers one byte, and its output enables drop before the next byte.
- R6: In page mode (mode bits 10), the address increments only within bits [4:0] after each byte, so it wraps inside a 32-byte page.
- R7: In burst mode (mode bits 01), the address increments through the full 17-bit space and wraps from 0x1FFFF to 0x00000.
- R8: The transfer mode is mode-register bits [7:6]. A read of the mode register returns those two bits, with bits [5:0] reading as 0.
- R9: In two-line mode, each serial clock moves 2 bits on lines [1:0], with line 1 carrying the more significant bit. A data read inserts one dummy byte after the address.
- R10: In four-line mode, each serial clock moves 4 bits on lines [3:0], with line 3 most significant. A data read inserts one dummy byte after the address.
- R11: `sio_oe` is nonzero only in the read-data phase while selected: 0010 in single-line mode, 0011 in two-line mode and 1111 in four-line mode.
- R12: When `cs_n` rises after the last bit of a write byte, that byte is stored. A byte left incomplete at the rise of `cs_n` is dropped. The line-width mode persists across accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select that frames each access |
| sck | input | 1 | Serial clock, synchronous to clk |
| sio_in | input | 4 | Serial data lines as received |
| sio_out | output | 4 | Serial data lines as driven |
| sio_oe | output | 4 | Per-line output enable |

## Verification
The falling serial edge that fetches the last byte of a page is the same `clk` cycle in which the address counter wraps to the page start. The bench writes a full page plus one extra byte, so that the write also wraps. It then reads across the page end and expects the byte after offset 31 to be the offset-0 data. In a separate case, select rises while the serial clock is still high, in the cycle right after a byte completes. The bench judges it by reading that byte back, next to a second write that is cut off mid-byte and must leave the old value in place.

// File: rtl/sramx_pkg.sv
package sramx_pkg;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_DUMMY, PH_WDATA, PH_RDATA, PH_MODEW, PH_IDLE
    } phase_e;

    // encoding equals mode-register bits [7:6]
    typedef enum logic [1:0] {
        XM_BYTE = 2'b00, XM_BURST = 2'b01, XM_PAGE = 2'b10, XM_RSVD = 2'b11
    } xfer_e;

    typedef enum logic [1:0] { LW_1, LW_2, LW_4 } lane_e;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_RDMODE = 8'h05;
    localparam logic [7:0] OP_WRMODE = 8'h01;
    localparam logic [7:0] OP_DUAL   = 8'h3B;
    localparam logic [7:0] OP_QUAD   = 8'h38;
    localparam logic [7:0] OP_SINGLE = 8'hFF;

    function automatic logic [3:0] lane_bits(lane_e l);
        case (l)
            LW_2:    return 4'd2;
            LW_4:    return 4'd4;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(lane_e l);
        case (l)
            LW_2:    return 4'b0011;
            LW_4:    return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

    // place the leading bits of a byte onto the data lines
    function automatic logic [3:0] lane_place(lane_e l, logic [7:0] b);
        case (l)
            LW_2:    return {2'b00, b[7:6]};
            LW_4:    return b[7:4];
            default: return {2'b00, b[7], 1'b0};
        endcase
    endfunction

endpackage

// File: rtl/sramx_edge_det.sv
module sramx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic sel,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign rise = sel & sck & ~sck_q;
    assign fall = sel & ~sck & sck_q;
endmodule

// File: rtl/sramx_addr_ctr.sv
module sramx_addr_ctr import sramx_pkg::*; #(
    parameter int ADDR_W  = 17,
    parameter int PAGE_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  xfer_e             xfer,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            if (xfer == XM_PAGE)
                addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + PAGE_AW'(1);
            else
                addr <= addr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/sramx_array.sv
module sramx_array #(
    parameter int ADDR_W   = 17,
    parameter int ARRAY_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [7:0]          mem [DEPTH];
    logic [ARRAY_AW-1:0] idx;

    assign idx   = ARRAY_AW'(addr % DEPTH);
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end
endmodule

// File: rtl/sramx_serial_slave.sv
module sramx_serial_slave import sramx_pkg::*; #(
    parameter int ADDR_W     = 17,
    parameter int PAGE_AW    = 5,
    parameter int ARRAY_AW   = 12,
    parameter int ADDR_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] sio_in,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe
);
    localparam int         ACC_W     = ADDR_W - 8;
    localparam logic [1:0] LAST_ADDR = 2'(ADDR_BYTES - 1);

    logic              rise, fall;
    phase_e            phase;
    lane_e             lane_q;
    xfer_e             xfer_q;
    logic [6:0]        in_sh;
    logic [2:0]        in_cnt, out_cnt;
    logic [1:0]        byte_idx;
    logic [ACC_W-1:0]  addr_acc;
    logic              rd_cmd, is_mreg, first_done;
    logic [7:0]        out_sh;
    logic [3:0]        stepw, in_sum, out_sum;
    logic [7:0]        in_next, rd_data, src;
    logic [ADDR_W-1:0] addr_full, addr;
    logic              byte_done, we, ld, fetch, stop_rd, step;

    sramx_edge_det edge_i (
        .clk(clk), .rst(rst), .sck(sck), .sel(~cs_n), .rise(rise), .fall(fall)
    );

    sramx_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) ctr_i (
        .clk(clk), .rst(rst), .load(ld), .load_val(addr_full),
        .step(step), .xfer(xfer_q), .addr(addr)
    );

    sramx_array #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) mem_i (
        .clk(clk), .we(we), .addr(addr), .wdata(in_next), .rdata(rd_data)
    );

    always_comb begin
        stepw = lane_bits(lane_q);
        case (lane_q)
            LW_2:    in_next = {in_sh[5:0], sio_in[1:0]};
            LW_4:    in_next = {in_sh[3:0], sio_in[3:0]};
            default: in_next = {in_sh[6:0], sio_in[0]};
        endcase
        in_sum    = {1'b0, in_cnt} + stepw;
        out_sum   = {1'b0, out_cnt} + stepw;
        byte_done = rise && (in_sum == 4'd8);
        addr_full = {addr_acc, in_next};
        we        = byte_done && (phase == PH_WDATA);
        ld        = byte_done && (phase == PH_ADDR) && (byte_idx == LAST_ADDR);
        stop_rd   = first_done && (is_mreg || !(xfer_q inside {XM_PAGE, XM_BURST}));
        fetch     = fall && (phase == PH_RDATA) && (out_cnt == 3'd0) && !stop_rd;
        step      = we || (fetch && !is_mreg);
        src       = is_mreg ? {xfer_q, 6'b0} : rd_data;
        sio_oe    = (!cs_n && phase == PH_RDATA) ? lane_mask(lane_q) : 4'b0000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            lane_q     <= LW_1;
            xfer_q     <= XM_BYTE;
            in_sh      <= '0;
            in_cnt     <= '0;
            out_cnt    <= '0;
            byte_idx   <= '0;
            addr_acc   <= '0;
            rd_cmd     <= 1'b0;
            is_mreg    <= 1'b0;
            first_done <= 1'b0;
            out_sh     <= '0;
            sio_out    <= '0;
        end else if (cs_n) begin
            phase      <= PH_CMD;
            in_cnt     <= '0;
            out_cnt    <= '0;
            byte_idx   <= '0;
            is_mreg    <= 1'b0;
            first_done <= 1'b0;
        end else if (rise) begin
            in_sh  <= in_next[6:0];
            in_cnt <= in_sum[2:0];
            if (byte_done) begin
                case (phase)
                    PH_CMD: begin
                        rd_cmd <= (in_next == OP_READ);
                        case (in_next)
                            OP_READ, OP_WRITE: phase <= PH_ADDR;
                            OP_RDMODE: begin
                                phase   <= PH_RDATA;
                                is_mreg <= 1'b1;
                            end
                            OP_WRMODE: phase <= PH_MODEW;
                            OP_DUAL:   begin lane_q <= LW_2; phase <= PH_IDLE; end
                            OP_QUAD:   begin lane_q <= LW_4; phase <= PH_IDLE; end
                            OP_SINGLE: begin lane_q <= LW_1; phase <= PH_IDLE; end
                            default:   phase <= PH_IDLE;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_acc <= addr_full[ACC_W-1:0];
                        byte_idx <= byte_idx + 2'd1;
                        if (byte_idx == LAST_ADDR) begin
                            if (!rd_cmd)            phase <= PH_WDATA;
                            else if (lane_q == LW_1) phase <= PH_RDATA;
                            else                     phase <= PH_DUMMY;
                        end
                    end
                    PH_DUMMY: phase <= PH_RDATA;
                    PH_WDATA: begin
                        if (!(xfer_q inside {XM_PAGE, XM_BURST})) phase <= PH_IDLE;
                    end
                    PH_MODEW: begin
                        xfer_q <= xfer_e'(in_next[7:6]);
                        phase  <= PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end else if (fall && phase == PH_RDATA) begin
            if (out_cnt == 3'd0 && stop_rd) begin
                phase <= PH_IDLE;
            end else begin
                out_cnt <= out_sum[2:0];
                if (out_cnt == 3'd0) begin
                    sio_out    <= lane_place(lane_q, src);
                    out_sh     <= src << stepw;
                    first_done <= 1'b1;
                end else begin
                    sio_out <= lane_place(lane_q, out_sh);
                    out_sh  <= out_sh << stepw;
                end
            end
        end
    end
endmodule

// File: rtl/sramx_serial_slave_chk.sv
module sramx_serial_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] sio_out,
    input logic [3:0] sio_oe
);
    // R11: deselected block drives nothing
    assert_oe_standby_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sio_oe == 4'b0000));

    // R11: only the three legal lane patterns ever appear
    assert_oe_shape_R11: assert property (@(posedge clk) disable iff (rst)
        (sio_oe == 4'b0000) || (sio_oe == 4'b0010) ||
        (sio_oe == 4'b0011) || (sio_oe == 4'b1111));

    // R2: outputs move only on a detected falling serial edge
    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !($past(sck) && !sck && !cs_n) |=> $stable(sio_out));

    // R12: the lane width stays fixed during a read burst
    assert_lane_steady_R12: assert property (@(posedge clk) disable iff (rst)
        (sio_oe != 4'b0000) && ($past(sio_oe) != 4'b0000) |-> $stable(sio_oe));
endmodule

bind sramx_serial_slave sramx_serial_slave_chk chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck),
    .sio_out(sio_out), .sio_oe(sio_oe)
);

// File: tb/sramx_serial_slave_tb_top.sv
module sramx_serial_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst, cs_n, sck;
    logic [3:0] sio_in, sio_out, sio_oe;

    int         tests = 0;
    int         fails = 0;
    int         tb_w  = 1;
    bit         done  = 1'b0;
    logic [3:0] last_oe;
    logic [7:0] rx_byte;
    logic [7:0] wbuf [0:39];
    logic [7:0] exp_d [$];
    string      exp_tag [$];
    event       rx_ev;

    always #4 clk = ~clk;

    sramx_serial_slave dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck),
        .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_byte(input logic [7:0] d, input string tag);
        exp_d.push_back(d);
        exp_tag.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(rx_ev);
            if (exp_d.size() == 0) begin
                tests++; fails++;
                $display("FAIL unexpected read actual=%h expected=none", rx_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_d.pop_front();
                t = exp_tag.pop_front();
                chk(rx_byte === e, t, rx_byte, e);
            end
        end
    end

    task automatic beat(input logic [3:0] din, output logic [3:0] dout, input bit cs_end);
        @(negedge clk) sio_in = din;
        repeat (2) @(negedge clk);
        dout = sio_out;
        last_oe = sio_oe;
        sck = 1'b1;
        repeat (2) @(negedge clk);
        if (cs_end) begin
            cs_n = 1'b1;
            @(negedge clk) sck = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input bit cs_end);
        logic [7:0] s;
        logic [3:0] d, q;
        s = tx; rx = '0;
        for (int i = 0; i < 8 / tb_w; i++) begin
            case (tb_w)
                1:       d = {3'b0, s[7]};
                2:       d = {2'b0, s[7:6]};
                default: d = s[7:4];
            endcase
            beat(d, q, cs_end && (i == 8 / tb_w - 1));
            case (tb_w)
                1:       rx = {rx[6:0], q[1]};
                2:       rx = {rx[5:0], q[1:0]};
                default: rx = {rx[3:0], q};
            endcase
            s = s << tb_w;
        end
    endtask

    task automatic start();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic stop();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xbyte(a[23:16], r, 1'b0);
        xbyte(a[15:8], r, 1'b0);
        xbyte(a[7:0], r, 1'b0);
    endtask

    task automatic wr(input logic [23:0] a, input int n);
        logic [7:0] r;
        start();
        xbyte(8'h02, r, 1'b0);
        send_addr(a);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], r, 1'b0);
        stop();
    endtask

    task automatic wr1(input logic [23:0] a, input logic [7:0] d);
        wbuf[0] = d;
        wr(a, 1);
    endtask

    task automatic rd(input logic [23:0] a, input int n, input int n_mon);
        logic [7:0] r;
        start();
        xbyte(8'h03, r, 1'b0);
        send_addr(a);
        if (tb_w > 1) xbyte(8'hFF, r, 1'b0);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, 1'b0);
            if (i < n_mon) begin
                rx_byte = r;
                ->rx_ev;
            end
        end
        stop();
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        start();
        xbyte(op, r, 1'b0);
        stop();
    endtask

    task automatic wmode(input logic [7:0] v);
        logic [7:0] r;
        start();
        xbyte(8'h01, r, 1'b0);
        xbyte(v, r, 1'b0);
        stop();
    endtask

    task automatic rmode();
        logic [7:0] r;
        start();
        xbyte(8'h05, r, 1'b0);
        xbyte(8'h00, r, 1'b0);
        rx_byte = r;
        ->rx_ev;
        stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic [3:0] q;
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sio_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sio_oe == 4'b0000, "R1 oe after reset", {4'b0, sio_oe}, 8'h00);

        // R1 R8: default mode register
        expect_byte(8'h00, "R1 R8 mode reg after reset");
        rmode();

        // R2 R4: single-line write/read, upper address bits ignored
        wr1(24'hFE0123, 8'hA5);
        expect_byte(8'hA5, "R2 R4 single-line read");
        rd(24'h000123, 1, 1);
        chk(last_oe == 4'b0010, "R11 single-line oe", {4'b0, last_oe}, 8'h02);

        // R5: byte mode stores one byte, reads one byte
        wr1(24'h000201, 8'h77);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr(24'h000200, 2);
        expect_byte(8'h77, "R5 extra write byte ignored");
        rd(24'h000201, 1, 1);
        expect_byte(8'h11, "R5 byte-mode read");
        rd(24'h000200, 2, 1);
        chk(last_oe == 4'b0000, "R5 oe off after one byte", {4'b0, last_oe}, 8'h00);

        // R8: mode register readback
        wmode(8'hFF);
        expect_byte(8'hC0, "R8 mode reg readback");
        rmode();

        // R7: burst mode wraps at end of space
        wmode(8'h40);
        wr1(24'h000420, 8'h99);
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
        wr(24'h01FFFE, 3);
        expect_byte(8'h7C, "R7 burst wrap to zero");
        rd(24'h000000, 1, 1);
        expect_byte(8'h5A, "R7 burst read 0");
        expect_byte(8'h6B, "R7 burst read 1");
        expect_byte(8'h7C, "R7 burst read 2");
        rd(24'h01FFFE, 3, 3);

        // R6: page wrap on write and read
        wmode(8'h80);
        for (int i = 0; i < 32; i++) wbuf[i] = 8'(i * 3 + 1);
        wbuf[32] = 8'hEE;
        wr(24'h000400, 33);
        expect_byte(8'h5E, "R6 page last byte");
        expect_byte(8'hEE, "R6 page wrap to start");
        rd(24'h00041F, 2, 2);
        expect_byte(8'h99, "R6 next page untouched");
        rd(24'h000420, 1, 1);

        // R3: unknown opcode ignored
        start();
        xbyte(8'h7A, r, 1'b0);
        send_addr(24'h000123);
        xbyte(8'h00, r, 1'b0);
        chk(last_oe == 4'b0000, "R3 unknown opcode no oe", {4'b0, last_oe}, 8'h00);
        stop();
        expect_byte(8'hA5, "R3 unknown opcode no write");
        rd(24'h000123, 1, 1);

        // R9: two-line mode
        cmd1(8'h3B);
        tb_w = 2;
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        wr(24'h000600, 2);
        expect_byte(8'hC3, "R9 dual read 0");
        expect_byte(8'h3C, "R9 dual read 1");
        rd(24'h000600, 2, 2);
        chk(last_oe == 4'b0011, "R11 dual oe", {4'b0, last_oe}, 8'h03);

        // R10: four-line mode
        cmd1(8'h38);
        tb_w = 4;
        wbuf[0] = 8'hF0; wbuf[1] = 8'h0F; wbuf[2] = 8'h96;
        wr(24'h000700, 3);
        expect_byte(8'hF0, "R10 quad read 0");
        expect_byte(8'h0F, "R10 quad read 1");
        expect_byte(8'h96, "R10 quad read 2");
        rd(24'h000700, 3, 3);
        chk(last_oe == 4'b1111, "R11 quad oe", {4'b0, last_oe}, 8'h0F);
        expect_byte(8'hC3, "R12 width persists quad");
        rd(24'h000600, 1, 1);

        // R3: back to single line
        cmd1(8'hFF);
        tb_w = 1;
        expect_byte(8'hA5, "R3 return to single line");
        rd(24'h000123, 1, 1);

        // R12: select rises right after a full byte
        start();
        xbyte(8'h02, r, 1'b0);
        send_addr(24'h000300);
        xbyte(8'h5C, r, 1'b1);
        chk(sio_oe == 4'b0000, "R11 oe off when deselected", {4'b0, sio_oe}, 8'h00);
        // R12: partial byte dropped
        start();
        xbyte(8'h02, r, 1'b0);
        send_addr(24'h000300);
        for (int i = 0; i < 4; i++) beat(4'b0001, q, 1'b0);
        stop();
        expect_byte(8'h5C, "R12 full byte kept, partial dropped");
        rd(24'h000300, 1, 1);

        repeat (4) @(negedge clk);
        chk(exp_d.size() == 0, "scoreboard drained", 8'(exp_d.size()), 8'h00);
        finish_run();
    end
endmodule